// File: doc/BRIEF.md
# Flash Word-Program Sequencer with Toggle Polling

This controller sits on the host side of a parallel NOR flash bus and carries out one word write per request. When idle it accepts an address and a data word. It then plays out the three protection-prefix write cycles and the address/data write cycle on the bus. After that it reads the target address repeatedly until the toggle status bit stops changing, and confirms the stored value with a final read. Every bus phase is counted in clock cycles, with parameters for setup, strobe, hold and read lengths.

A status read can land just as the internal write finishes, so a single verification read that disagrees with the written word is not trusted. Two further reads are taken. An error is reported only if the disagreement shows up again. If the toggle bit keeps changing for longer than a parameter number of cycles, the operation ends with a timeout instead. Each request finishes with a one-cycle done pulse. The error and timeout flags beside it stay valid until the next request is accepted.

Top module: `flash_prog_poller`

## Requirements
- R1: After reset the block is idle, `ce_n`, `we_n` and `oe_n` are high, `dq_oe` is low and `done` is low.
- R2: An accepted request produces exactly four write strobes in this order: (UNLK_A1, UNLK_D1), (UNLK_A2, UNLK_D2), (UNLK_A1, PRG_CMD), (request address, request data). With defaults these are 0x555/0xAA, 0x2AA/0x55 and 0x555/0xA0.
- R3: On every write cycle the address is already on `fa` in the cycle before `we_n` falls. The address and data are unchanged and `dq_oe` is high when `we_n` rises. `oe_n` is never low while `we_n` is low.
- R4: After the last write the block issues read cycles at the request address, with `oe_n` low and `dq_oe` low. Polling ends at the first read whose bit TBIT (default 6) equals that bit of the read just before it.
- R5: The first verification read after polling is compared with the request data. A match ends the operation with `done` pulsed and `err` low.
- R6: If the first verification read mismatches, two further reads are made. If both match, the operation ends without error.
- R7: If a confirmation read also mismatches, the operation ends at once with `err` high alongside `done`.
- R8: If polling lasts TIMEOUT cycles without the toggle bit settling, the operation ends with `tmo` high, `err` low and no verification reads.
- R9: `done` is high for exactly one cycle. Requests arriving while the block is busy are ignored. `err` and `tmo` keep their value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request, taken only when idle |
| req_addr | input | AW | Word address to program |
| req_data | input | DW | Word value to program |
| idle | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Verified data disagreed, valid with done |
| tmo | output | 1 | Toggle bit never settled, valid with done |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| fa | output | AW | Flash address bus |
| dq_out | output | DW | Data driven to the flash |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DW | Data returned by the flash |

## Verification
The hardest case to reach is the path where the toggle bit has settled but a verification read still disagrees. A real device only shows this when the program completes during a status read. The bench's flash model returns a programmable number of toggling reads. It then corrupts low data bits, leaving the toggle bit alone, on a chosen subset of the first three verification reads. Sweeping that subset over all eight patterns, with several toggle counts and data words, covers every branch of the confirm step. The total read count is checked against the number of reads each pattern should take.

// File: rtl/flash_prog_poller.sv
module flash_prog_poller #(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int TBIT = 6,
  parameter int T_SU = 1,
  parameter int T_WP = 2,
  parameter int T_HD = 1,
  parameter int T_RD = 2,
  parameter int TIMEOUT = 1000,
  parameter logic [AW-1:0] UNLK_A1 = AW'(12'h555),
  parameter logic [AW-1:0] UNLK_A2 = AW'(12'h2AA),
  parameter logic [DW-1:0] UNLK_D1 = DW'(8'hAA),
  parameter logic [DW-1:0] UNLK_D2 = DW'(8'h55),
  parameter logic [DW-1:0] PRG_CMD = DW'(8'hA0)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          idle,
  output logic          done,
  output logic          err,
  output logic          tmo,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [AW-1:0] fa,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);
  localparam int TMAX = (T_SU > T_WP ? (T_SU > T_HD ? T_SU : T_HD) : (T_WP > T_HD ? T_WP : T_HD)) > T_RD ?
                        (T_SU > T_WP ? (T_SU > T_HD ? T_SU : T_HD) : (T_WP > T_HD ? T_WP : T_HD)) : T_RD;
  localparam int PCW = $clog2(TMAX + 1) + 1;
  localparam int TW = $clog2(TIMEOUT + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_POLL, S_VERIFY} st_t;
  st_t st;
  logic [1:0] ph, widx, vcnt;
  logic [PCW-1:0] pc, plen;
  logic [TW-1:0] tcnt;
  logic [AW-1:0] a_q, wr_addr;
  logic [DW-1:0] d_q;
  logic prev6, have_prev, settled, vok, conf;
  logic last, is_read;

  assign idle    = (st == S_IDLE);
  assign is_read = (st == S_POLL) || (st == S_VERIFY);
  assign ce_n    = idle;
  assign we_n    = !((st == S_WRITE) && (ph == 2'd1));
  assign oe_n    = !(is_read && (ph == 2'd0));
  assign dq_oe   = (st == S_WRITE);
  assign wr_addr = (widx == 2'd3) ? a_q : (widx == 2'd1) ? UNLK_A2 : UNLK_A1;
  assign fa      = (st == S_WRITE) ? wr_addr : a_q;
  assign dq_out  = (widx == 2'd0) ? UNLK_D1 : (widx == 2'd1) ? UNLK_D2 :
                   (widx == 2'd2) ? PRG_CMD : d_q;

  always_comb begin
    if (st == S_WRITE)
      plen = (ph == 2'd0) ? PCW'(T_SU - 1) : (ph == 2'd1) ? PCW'(T_WP - 1) : PCW'(T_HD - 1);
    else if (is_read)
      plen = (ph == 2'd0) ? PCW'(T_RD - 1) : '0;
    else
      plen = '0;
  end
  assign last = (pc == plen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; pc <= '0; widx <= '0; vcnt <= '0; tcnt <= '0;
      a_q <= '0; d_q <= '0; prev6 <= 1'b0; have_prev <= 1'b0; settled <= 1'b0;
      vok <= 1'b0; conf <= 1'b0; done <= 1'b0; err <= 1'b0; tmo <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          st <= S_WRITE; ph <= '0; pc <= '0; widx <= '0;
          a_q <= req_addr; d_q <= req_data; err <= 1'b0; tmo <= 1'b0;
        end
      end else if (st == S_POLL && tcnt == TW'(TIMEOUT - 1)) begin
        st <= S_IDLE; done <= 1'b1; tmo <= 1'b1;
      end else begin
        if (st == S_POLL) tcnt <= tcnt + 1'b1;
        if (!last) pc <= pc + 1'b1;
        else begin
          pc <= '0;
          unique case (st)
            S_WRITE: begin
              if (ph != 2'd2) ph <= ph + 1'b1;
              else begin
                ph <= '0;
                if (widx == 2'd3) begin
                  st <= S_POLL; have_prev <= 1'b0; settled <= 1'b0; tcnt <= '0;
                end else widx <= widx + 1'b1;
              end
            end
            S_POLL: begin
              if (ph == 2'd0) begin
                ph <= 2'd1;
                settled <= have_prev && (dq_in[TBIT] == prev6);
                prev6 <= dq_in[TBIT];
                have_prev <= 1'b1;
              end else begin
                ph <= '0;
                if (settled) begin
                  st <= S_VERIFY; conf <= 1'b0; vcnt <= '0;
                end
              end
            end
            S_VERIFY: begin
              if (ph == 2'd0) begin
                ph <= 2'd1;
                vok <= (dq_in == d_q);
              end else begin
                ph <= '0;
                if (!conf) begin
                  if (vok) begin st <= S_IDLE; done <= 1'b1; end
                  else conf <= 1'b1;
                end else if (!vok) begin
                  st <= S_IDLE; done <= 1'b1; err <= 1'b1;
                end else if (vcnt == 2'd1) begin
                  st <= S_IDLE; done <= 1'b1;
                end else vcnt <= vcnt + 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assert_addr_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $stable(fa) && !ce_n);
  assert_data_held_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe && $stable(dq_out) && $stable(fa));
  assert_no_read_during_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  assert_done_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_timeout_excludes_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> done && !err);
  assert_read_not_driving_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
endmodule

// File: tb/flash_prog_poller_test.sv
module flash_prog_poller_test;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int TO = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic idle, done, err, tmo, ce_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] fa;
  logic [DW-1:0] dq_out;
  logic [DW-1:0] dq_in = '0;

  flash_prog_poller #(.AW(AW), .DW(DW), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .idle(idle), .done(done), .err(err), .tmo(tmo),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .fa(fa), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in));

  int checks = 0;
  int fails = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int busy_left = 0, b_cur = 0, post_idx = 0, p_cnt = 1, bmask = 0, rd_cnt = 0, wn = 0;
  logic tog = 1'b0;
  logic [DW-1:0] tdata = '0;
  logic [AW-1:0] wa [4];
  logic [DW-1:0] wd [4];
  logic [AW-1:0] fall_a;
  logic [DW-1:0] fall_d;

  always @(negedge we_n) begin
    fall_a = fa;
    fall_d = dq_out;
  end

  always @(posedge we_n) if (rst_n) begin
    chk(fa == fall_a, "R3 address stable through strobe", int'(fa), int'(fall_a));
    chk(dq_out == fall_d && dq_oe && oe_n, "R3 data held and driven", int'(dq_out), int'(fall_d));
    if (wn < 4) begin
      wa[wn] = fa;
      wd[wn] = dq_out;
    end
    wn++;
    if (wn == 4) busy_left = b_cur;
  end

  always @(negedge oe_n) if (rst_n) begin
    rd_cnt++;
    if (busy_left > 0) begin
      dq_in = tdata ^ 8'h3C;
      dq_in[6] = tog;
      tog = ~tog;
      busy_left--;
    end else begin
      dq_in = tdata;
      if (post_idx >= p_cnt && post_idx - p_cnt < 3 && bmask[post_idx - p_cnt])
        dq_in = tdata ^ 8'h01;
      post_idx++;
    end
  end

  task automatic run(logic [AW-1:0] a, logic [DW-1:0] d, int b, int m, bit exp_tmo, bit poke);
    int n;
    bit exp_err;
    int v;
    tdata = d; b_cur = b; bmask = m; wn = 0; rd_cnt = 0; post_idx = 0; tog = 1'b0; busy_left = 0;
    p_cnt = (((b - 1) & 1) == int'(d[6])) ? 1 : 2;
    @(negedge clk);
    req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      req_addr = ~a; req_data = ~d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, "R9 done reached", n, 0);
    exp_err = !exp_tmo && m[0] && (m[1] || m[2]);
    v = !m[0] ? 1 : (m[1] ? 2 : 3);
    chk(wn == 4, "R2 four strobes", wn, 4);
    chk(wa[0] == 12'h555 && wd[0] == 8'hAA, "R2 first prefix", int'(wd[0]), 'hAA);
    chk(wa[1] == 12'h2AA && wd[1] == 8'h55, "R2 second prefix", int'(wd[1]), 'h55);
    chk(wa[2] == 12'h555 && wd[2] == 8'hA0, "R2 program command", int'(wd[2]), 'hA0);
    chk(wa[3] == a && wd[3] == d, "R2 R9 target word", int'(wd[3]), int'(d));
    chk(tmo == exp_tmo, "R8 timeout flag", int'(tmo), int'(exp_tmo));
    chk(err == exp_err, "R5 R6 R7 error flag", int'(err), int'(exp_err));
    if (!exp_tmo)
      chk(rd_cnt == b + p_cnt + v, "R4 R6 read count", rd_cnt, b + p_cnt + v);
    @(negedge clk);
    chk(!done && idle, "R9 done one cycle", int'(done), 0);
    chk(err == exp_err && tmo == exp_tmo, "R9 flags held", int'(err), int'(exp_err));
    repeat (3) @(negedge clk);
    chk(ce_n && idle && wn == 4, "R9 no stray operation", wn, 4);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    chk(0, "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'h5A; pats[2] = 8'hC3; pats[3] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(idle && ce_n && we_n && oe_n && !dq_oe && !done, "R1 reset outputs", int'(idle), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle && ce_n && we_n && oe_n && !dq_oe && !done, "R1 after release", int'(idle), 1);
    for (int pi = 0; pi < 4; pi++)
      for (int b = 1; b <= 4; b++)
        for (int m = 0; m < 8; m++)
          run(AW'(pi * 291 + b * 17 + m), pats[pi], b, m, 1'b0, 1'b0);
    run(12'h0F0, 8'h3E, 3, 1, 1'b0, 1'b1);
    run(12'h123, 8'h77, 100, 0, 1'b1, 1'b0);
    run(12'h456, 8'h40, 2, 3, 1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule